// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block is a state machine that holds the power mode of a chip and decides every move between modes. Six modes are tracked: full-speed run, plain stop, very-low-power run, very-low-power wait, very-low-power stop and very-low-leakage stop. A leakage sub-mode field chooses the variant of the last one. Software-owned permission bits gate entry to the very-low-power and very-low-leakage modes. Mode-select fields name the target. A one-cycle sleep strobe, qualified by a deep-sleep flag, triggers the stop-class and wait transitions. An interrupt, a wakeup-source input or the asynchronous reset brings the chip back.

The very-low-power stop mode records whether it was entered from full-speed run or from very-low-power run. An interrupt then returns it to the mode it came from. A request that lacks its permission bit, or that names an undefined field value, leaves the mode unchanged and raises a rejection flag. The current mode is reported as a one-hot vector, and the leakage sub-mode that was latched on entry is reported beside it.

Top module: `lp_mode_ctrl`

## Requirements
- R1: An active-low `rst_n` forces RUN at once from any mode. It also clears the latched sub-mode to 0 and clears the rejection flag.
- R2: In RUN with `run_sel`=2'b10 and `allow_vlp`=1, the next mode is VLPR. In VLPR with `run_sel`=2'b00 and no sleep strobe, the next mode is RUN.
- R3: In VLPR, a sleep strobe with `deep_sleep`=0 gives VLPW. In VLPW, `irq` gives VLPR, and every other input, including a sleep strobe, leaves VLPW unchanged.
- R4: In VLPR, a deep sleep strobe with `stop_sel` equal to 3'b000 or 3'b010 gives VLPS. In RUN, a deep sleep strobe with `stop_sel`=3'b010 and `allow_vlp`=1 gives VLPS.
- R5: In VLPS, `irq` returns to RUN if VLPS was entered from RUN, and to VLPR if it was entered from VLPR. Without `irq`, VLPS holds.
- R6: In RUN or VLPR, a deep sleep strobe with `stop_sel`=3'b100 and `allow_vlls`=1 gives VLLS and latches `vlls_sel` into `vlls_mode`. `vlls_mode` changes only on such an entry.
- R7: VLLS leaves only to RUN, and only on `wake`. In RUN, a deep sleep strobe with `stop_sel`=3'b000 gives STOP, and in STOP `irq` returns to RUN.
- R8: In RUN or VLPR, any of the following keeps the mode and sets `req_rejected`, which stays set until reset: a missing permission bit, a deep sleep strobe with `stop_sel` of 3'b001, 3'b011 or 3'b101..3'b111, or `run_sel` of 2'b01 or 2'b11.
- R9: In RUN and VLPR, a sleep strobe takes priority over `run_sel` in the same cycle. A sleep strobe with `deep_sleep`=0 in RUN has no effect and is not a rejection.
- R10: `mode_oh` is one-hot with bit 0 = RUN, 1 = STOP, 2 = VLPR, 3 = VLPW, 4 = VLPS and 5 = VLLS. It shows a transition one clock after the trigger is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allow_vlp | input | 1 | Permits very-low-power run and stop entry |
| allow_vlls | input | 1 | Permits very-low-leakage stop entry |
| run_sel | input | 2 | Run-mode select: 00 run, 10 very-low-power run |
| stop_sel | input | 3 | Stop-mode select: 000 stop, 010 VLPS, 100 VLLS |
| vlls_sel | input | SUB_W | Leakage sub-mode to latch on VLLS entry |
| sleep_req | input | 1 | Single-cycle sleep strobe |
| deep_sleep | input | 1 | Qualifies the strobe as a deep sleep |
| irq | input | 1 | Interrupt wake |
| wake | input | 1 | Enabled wakeup-source event |
| mode_oh | output | 6 | One-hot current mode |
| vlls_mode | output | SUB_W | Latched leakage sub-mode |
| req_rejected | output | 1 | A request was refused |

## Verification
Two functions can fall in the same cycle: a sleep strobe and a run-select change. In RUN and VLPR the strobe and a move driven by `run_sel` compete for the same next-state slot. The bench provokes this twice. In the first case it drives `run_sel`=2'b10 together with a deep stop strobe in RUN. In the second it drives `run_sel`=2'b00 together with a shallow strobe in VLPR. The mode sampled one clock later must be STOP and then VLPW, showing that the strobe won. The bench also confirms that the losing request leaves no rejection behind.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [2:0] {
      M_RUN  = 3'd0,
      M_STOP = 3'd1,
      M_VLPR = 3'd2,
      M_VLPW = 3'd3,
      M_VLPS = 3'd4,
      M_VLLS = 3'd5
   } mode_e;

   localparam int unsigned NUM_MODES = 6;

   localparam logic [1:0] RSEL_FULL = 2'b00;
   localparam logic [1:0] RSEL_LOWP = 2'b10;

   localparam logic [2:0] SSEL_STOP = 3'b000;
   localparam logic [2:0] SSEL_VLPS = 3'b010;
   localparam logic [2:0] SSEL_VLLS = 3'b100;
endpackage

// File: rtl/lpm_next.sv
module lpm_next
   import lpm_pkg::*;
(
   input  mode_e      cur_i,
   input  logic       from_run_i,
   input  logic       allow_vlp_i,
   input  logic       allow_vlls_i,
   input  logic [1:0] run_sel_i,
   input  logic [2:0] stop_sel_i,
   input  logic       sleep_i,
   input  logic       deep_i,
   input  logic       irq_i,
   input  logic       wake_i,
   output mode_e      nxt_o,
   output logic       from_run_o,
   output logic       take_sub_o,
   output logic       reject_o
);
   // a deep request common to RUN and VLPR for the leakage target
   always_comb begin
      nxt_o      = cur_i;
      from_run_o = from_run_i;
      take_sub_o = 1'b0;
      reject_o   = 1'b0;
      unique case (cur_i)
         M_RUN: begin
            if (sleep_i) begin
               if (deep_i) begin
                  case (stop_sel_i)
                     SSEL_STOP: nxt_o = M_STOP;
                     SSEL_VLPS: begin
                        if (allow_vlp_i) begin
                           nxt_o      = M_VLPS;
                           from_run_o = 1'b1;
                        end else reject_o = 1'b1;
                     end
                     SSEL_VLLS: begin
                        if (allow_vlls_i) begin
                           nxt_o      = M_VLLS;
                           take_sub_o = 1'b1;
                        end else reject_o = 1'b1;
                     end
                     default: reject_o = 1'b1;
                  endcase
               end
            end else if (run_sel_i == RSEL_LOWP) begin
               if (allow_vlp_i) nxt_o = M_VLPR;
               else             reject_o = 1'b1;
            end else if (run_sel_i != RSEL_FULL) begin
               reject_o = 1'b1;
            end
         end
         M_VLPR: begin
            if (sleep_i) begin
               if (!deep_i) nxt_o = M_VLPW;
               else begin
                  case (stop_sel_i)
                     SSEL_STOP, SSEL_VLPS: begin
                        nxt_o      = M_VLPS;
                        from_run_o = 1'b0;
                     end
                     SSEL_VLLS: begin
                        if (allow_vlls_i) begin
                           nxt_o      = M_VLLS;
                           take_sub_o = 1'b1;
                        end else reject_o = 1'b1;
                     end
                     default: reject_o = 1'b1;
                  endcase
               end
            end else if (run_sel_i == RSEL_FULL) begin
               nxt_o = M_RUN;
            end else if (run_sel_i != RSEL_LOWP) begin
               reject_o = 1'b1;
            end
         end
         M_VLPW: if (irq_i) nxt_o = M_VLPR;
         M_VLPS: begin
            if (irq_i) begin
               nxt_o      = from_run_i ? M_RUN : M_VLPR;
               from_run_o = 1'b0;
            end
         end
         M_STOP: if (irq_i) nxt_o = M_RUN;
         M_VLLS: if (wake_i) nxt_o = M_RUN;
         default: nxt_o = M_RUN;
      endcase
   end
endmodule

// File: rtl/lpm_reject.sv
module lpm_reject #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   output logic flag_o
);
   generate
      if (STICKY) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_o <= 1'b0;
            else        flag_o <= flag_o | set_i;
         end
      end else begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_o <= 1'b0;
            else        flag_o <= set_i;
         end
      end
   endgenerate
endmodule

// File: rtl/lpm_onehot.sv
module lpm_onehot
   import lpm_pkg::*;
#(
   parameter int unsigned N = NUM_MODES
) (
   input  mode_e        mode_i,
   output logic [N-1:0] oh_o
);
   localparam int unsigned EW = $bits(mode_e);

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign oh_o[i] = (mode_i == mode_e'(EW'(i)));
   end
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
   import lpm_pkg::*;
#(
   parameter int unsigned SUB_W         = 2,
   parameter bit          REJECT_STICKY = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 allow_vlp,
   input  logic                 allow_vlls,
   input  logic [1:0]           run_sel,
   input  logic [2:0]           stop_sel,
   input  logic [SUB_W-1:0]     vlls_sel,
   input  logic                 sleep_req,
   input  logic                 deep_sleep,
   input  logic                 irq,
   input  logic                 wake,
   output logic [NUM_MODES-1:0] mode_oh,
   output logic [SUB_W-1:0]     vlls_mode,
   output logic                 req_rejected
);
   generate
      if (SUB_W < 1 || SUB_W > 4) begin : g_bad_sub_w
         $error("lp_mode_ctrl: SUB_W must lie in 1..4");
      end
   endgenerate

   mode_e            mode_q, mode_d;
   logic             from_run_q, from_run_d;
   logic             take_sub, rej_pulse;
   logic [SUB_W-1:0] sub_q;

   lpm_next u_next (
      .cur_i        (mode_q),
      .from_run_i   (from_run_q),
      .allow_vlp_i  (allow_vlp),
      .allow_vlls_i (allow_vlls),
      .run_sel_i    (run_sel),
      .stop_sel_i   (stop_sel),
      .sleep_i      (sleep_req),
      .deep_i       (deep_sleep),
      .irq_i        (irq),
      .wake_i       (wake),
      .nxt_o        (mode_d),
      .from_run_o   (from_run_d),
      .take_sub_o   (take_sub),
      .reject_o     (rej_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= M_RUN;
         from_run_q <= 1'b0;
         sub_q      <= '0;
      end else begin
         mode_q     <= mode_d;
         from_run_q <= from_run_d;
         if (take_sub) sub_q <= vlls_sel;
      end
   end

   lpm_reject #(.STICKY(REJECT_STICKY)) u_rej (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (rej_pulse),
      .flag_o (req_rejected)
   );

   lpm_onehot #(.N(NUM_MODES)) u_oh (
      .mode_i (mode_q),
      .oh_o   (mode_oh)
   );

   assign vlls_mode = sub_q;
endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk
   import lpm_pkg::*;
#(
   parameter int unsigned SUB_W         = 2,
   parameter bit          REJECT_STICKY = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 irq,
   input logic                 wake,
   input logic [NUM_MODES-1:0] mode_oh,
   input logic [SUB_W-1:0]     vlls_mode,
   input logic                 req_rejected
);
   localparam int IX_RUN  = int'(M_RUN);
   localparam int IX_STOP = int'(M_STOP);
   localparam int IX_VLPR = int'(M_VLPR);
   localparam int IX_VLPW = int'(M_VLPW);
   localparam int IX_VLPS = int'(M_VLPS);
   localparam int IX_VLLS = int'(M_VLLS);

   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_oh) == 1);

   a_r3_vlpw_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[IX_VLPW] && irq) |=> mode_oh[IX_VLPR]);

   a_r3_vlpw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[IX_VLPW] && !irq) |=> mode_oh[IX_VLPW]);

   a_r4_vlps_origin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_oh[IX_VLPS]) |-> $past(mode_oh[IX_RUN] || mode_oh[IX_VLPR]));

   a_r6_sub_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vlls_mode) |-> $rose(mode_oh[IX_VLLS]));

   a_r7_vlls_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[IX_VLLS] && !wake) |=> mode_oh[IX_VLLS]);

   a_r7_vlls_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[IX_VLLS] && wake) |=> mode_oh[IX_RUN]);

   a_r7_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[IX_STOP] && irq) |=> mode_oh[IX_RUN]);

   generate
      if (REJECT_STICKY) begin : g_sticky_chk
         a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            req_rejected |=> req_rejected);
      end
   endgenerate
endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk #(
   .SUB_W         (SUB_W),
   .REJECT_STICKY (REJECT_STICKY)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq          (irq),
   .wake         (wake),
   .mode_oh      (mode_oh),
   .vlls_mode    (vlls_mode),
   .req_rejected (req_rejected)
);

// File: tb/lp_mode_ctrl_tb.sv
module lp_mode_ctrl_tb;
   localparam time CYC = 20ns;
   localparam int  SW  = 2;

   localparam logic [5:0] O_RUN  = 6'b000001;
   localparam logic [5:0] O_STOP = 6'b000010;
   localparam logic [5:0] O_VLPR = 6'b000100;
   localparam logic [5:0] O_VLPW = 6'b001000;
   localparam logic [5:0] O_VLPS = 6'b010000;
   localparam logic [5:0] O_VLLS = 6'b100000;

   typedef struct {
      logic [5:0]    oh;
      logic          rj;
      logic [SW-1:0] sub;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          allow_vlp = 1'b0, allow_vlls = 1'b0;
   logic [1:0]    run_sel = '0;
   logic [2:0]    stop_sel = '0;
   logic [SW-1:0] vlls_sel = '0;
   logic          sleep_req = 1'b0, deep_sleep = 1'b0, irq = 1'b0, wake = 1'b0;
   logic [5:0]    mode_oh;
   logic [SW-1:0] vlls_mode;
   logic          req_rejected;

   exp_t          exp_q[$];
   logic          e_rej = 1'b0;
   logic [SW-1:0] e_sub = '0;
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;

   always #(CYC/2) clk = ~clk;

   lp_mode_ctrl #(.SUB_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .allow_vlp(allow_vlp), .allow_vlls(allow_vlls),
      .run_sel(run_sel), .stop_sel(stop_sel), .vlls_sel(vlls_sel),
      .sleep_req(sleep_req), .deep_sleep(deep_sleep), .irq(irq), .wake(wake),
      .mode_oh(mode_oh), .vlls_mode(vlls_mode), .req_rejected(req_rejected)
   );

   task automatic compare(input exp_t it);
      n_chk++;
      if (mode_oh !== it.oh || req_rejected !== it.rj || vlls_mode !== it.sub) begin
         n_fail++;
         $display("FAIL %s: mode=%b rej=%b sub=%0d expected mode=%b rej=%b sub=%0d",
                  it.tag, mode_oh, req_rejected, vlls_mode, it.oh, it.rj, it.sub);
      end
   endtask

   // monitor: pops one expectation per clock, sampled after the edge
   initial forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
   end

   // driver: queue the expected result of the stimulus set this cycle
   task automatic tick(input logic [5:0] oh, input string tag);
      exp_t it;
      it.oh = oh; it.rj = e_rej; it.sub = e_sub; it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      sleep_req = 1'b0; deep_sleep = 1'b0; irq = 1'b0; wake = 1'b0;
   endtask

   task automatic deep(input logic [2:0] s);
      sleep_req = 1'b1; deep_sleep = 1'b1; stop_sel = s;
   endtask

   task automatic do_reset(input string tag);
      exp_t it;
      while (exp_q.size() != 0) @(negedge clk);
      rst_n = 1'b0;
      allow_vlp = 1'b0; allow_vlls = 1'b0; run_sel = '0; stop_sel = '0;
      e_rej = 1'b0; e_sub = '0;
      #2;
      it.oh = O_RUN; it.rj = 1'b0; it.sub = '0; it.tag = tag;
      compare(it);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CYC * 5000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset("R1 initial reset state");
      // R8 permission missing, then sticky
      run_sel = 2'b10; e_rej = 1'b1;
      tick(O_RUN, "R8 vlpr request without permission");
      run_sel = 2'b00;
      tick(O_RUN, "R8 rejection stays set");
      do_reset("R1 reset clears rejection");
      // R9 shallow sleep in RUN
      sleep_req = 1'b1;
      tick(O_RUN, "R9 shallow sleep in run ignored");
      allow_vlp = 1'b1; run_sel = 2'b10;
      tick(O_VLPR, "R2 run to vlpr");
      sleep_req = 1'b1;
      tick(O_VLPW, "R3 vlpr to vlpw");
      deep(3'b010);
      tick(O_VLPW, "R3 sleep in vlpw ignored");
      irq = 1'b1;
      tick(O_VLPW == 6'b0 ? O_RUN : O_VLPR, "R3 irq back to vlpr");
      deep(3'b010);
      tick(O_VLPS, "R4 vlpr to vlps via 010");
      tick(O_VLPS, "R5 vlps holds without irq");
      irq = 1'b1;
      tick(O_VLPR, "R5 vlps from vlpr returns to vlpr");
      deep(3'b000);
      tick(O_VLPS, "R4 vlpr to vlps via 000");
      irq = 1'b1;
      tick(O_VLPR, "R5 second return to vlpr");
      run_sel = 2'b00;
      tick(O_RUN, "R2 vlpr exit on 00");
      deep(3'b010);
      tick(O_VLPS, "R4 direct run to vlps");
      run_sel = 2'b10; irq = 1'b1;
      tick(O_RUN, "R5 direct entry returns to run");
      tick(O_VLPR, "R2 run to vlpr after wake");
      run_sel = 2'b00;
      tick(O_RUN, "R2 vlpr exit");
      // R7 plain stop
      deep(3'b000);
      tick(O_STOP, "R7 run to stop");
      tick(O_STOP, "R7 stop holds");
      irq = 1'b1;
      tick(O_RUN, "R7 stop irq to run");
      // R9 strobe beats run select in RUN
      run_sel = 2'b10; deep(3'b000);
      tick(O_STOP, "R9 sleep beats run select in run");
      run_sel = 2'b00; irq = 1'b1;
      tick(O_RUN, "R7 stop exit");
      // R6 leakage entry from RUN
      allow_vlls = 1'b1; vlls_sel = 2'd3; deep(3'b100); e_sub = 2'd3;
      tick(O_VLLS, "R6 run to vlls latches sub-mode");
      irq = 1'b1; vlls_sel = 2'd0;
      tick(O_VLLS, "R7 irq does not leave vlls");
      wake = 1'b1;
      tick(O_RUN, "R7 wake leaves vlls to run");
      run_sel = 2'b10;
      tick(O_VLPR, "R2 enter vlpr");
      vlls_sel = 2'd1; deep(3'b100); e_sub = 2'd1;
      tick(O_VLLS, "R6 vlpr to vlls");
      run_sel = 2'b00; wake = 1'b1;
      tick(O_RUN, "R7 wake to run only");
      // R9 strobe beats run select in VLPR
      run_sel = 2'b10;
      tick(O_VLPR, "R2 enter vlpr again");
      run_sel = 2'b00; sleep_req = 1'b1;
      tick(O_VLPW, "R9 sleep beats run select in vlpr");
      irq = 1'b1;
      tick(O_VLPR, "R3 irq to vlpr");
      tick(O_RUN, "R2 pending 00 exits vlpr");
      // R8 invalid fields
      run_sel = 2'b10;
      tick(O_VLPR, "R2 enter vlpr for invalid field test");
      deep(3'b011); e_rej = 1'b1;
      tick(O_VLPR, "R8 invalid stop select keeps vlpr");
      run_sel = 2'b01;
      tick(O_VLPR, "R8 invalid run select keeps vlpr");
      run_sel = 2'b00;
      tick(O_RUN, "R2 exit after rejections");
      allow_vlls = 1'b0; deep(3'b100);
      tick(O_RUN, "R8 vlls without permission");
      // R1 asynchronous reset out of VLPW
      allow_vlp = 1'b1; run_sel = 2'b10;
      tick(O_VLPR, "R2 enter vlpr before reset");
      sleep_req = 1'b1;
      tick(O_VLPW, "R3 enter vlpw before reset");
      do_reset("R1 reset from vlpw to run");
      tick(O_RUN, "R1 run after reset release");
      while (exp_q.size() != 0) @(negedge clk);
      finish_run();
   end
endmodule